// File: doc/BRIEF.md
# ADC Code-Width Timing Monitor

This block is self-test logic that sits beside an analog-to-digital converter while a rising ramp (the up slope of a triangle wave) drives its input. It checks one target code. A start pulse sets a timestamp counter to zero. The block then records the clock count at which the output code steps onto the target code, and the count at which it leaves the target code upward. Each of these two times is compared with an ideal time that software supplies. The block gives both signed deviations and their difference, which is the differential linearity error of the target code in clock cycles.

The result is the measured code width minus the ideal code width. The block compares its magnitude against a limit and raises a one-cycle done pulse with a pass or fail verdict. A code that never appears, or a ramp that stalls, ends in a timeout, and a timeout is a failure. The whole measurement uses a fixed, small set of registers: two latched ideal times, two captured times and two deviations. The amount of storage does not depend on the code width. Sweeping across all codes is done by repeated runs with a new target each time.

Top module: `adc_dle_bist`

## Requirements
- R1: After reset, busy_o, done_o, fail_o and timeout_o are 0, and act_lo_o, act_hi_o, dev_lo_o, dev_hi_o and dle_o are 0.
- R2: Start is sampled on a clock edge. That edge clears every result and flag, latches ideal_lo_i and ideal_hi_i, and sets busy_o. The first edge after the start edge has timestamp 0, and each later edge adds 1.
- R3: act_lo_o is the timestamp of the first edge at which code_i equals target_i, provided that code_i was below target_i at some earlier edge of the run. Samples at or above the target before any sample below it are ignored.
- R4: act_hi_o is the timestamp of the first edge after the lower capture at which code_i is greater than target_i. Dips below the target in between are ignored.
- R5: dev_lo_o equals act_lo_o minus the latched ideal lower time, and dev_hi_o equals act_hi_o minus the latched ideal upper time, both as two's complement. A negative value means the edge came early.
- R6: On a completed run, dle_o equals dev_hi_o minus dev_lo_o, which is the measured width minus the ideal width.
- R7: On a completed run, fail_o is 1 exactly when the magnitude of dle_o is greater than limit_i. A magnitude equal to the limit passes.
- R8: If no upper edge has been captured by the edge whose timestamp equals TIMEOUT_CYC, the run ends with timeout_o = 1, fail_o = 1 and dle_o = 0. A target code that the ramp skips ends this way.
- R9: busy_o drops after the upper-capture edge. done_o is high for exactly one cycle, which starts at the edge after the upper-capture edge (or after the timeout edge).
- R10: Once a run has ended, changes on code_i do not alter any result output until the next start.
- R11: A start while busy_o is 1 abandons the run in progress and begins a fresh measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a measurement |
| code_i | input | CODE_W | Converter output code |
| target_i | input | CODE_W | Code under test |
| ideal_lo_i | input | TIME_W | Ideal timestamp of the lower edge |
| ideal_hi_i | input | TIME_W | Ideal timestamp of the upper edge |
| limit_i | input | TIME_W | Largest allowed magnitude of the error |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| fail_o | output | 1 | Error over limit or timeout |
| timeout_o | output | 1 | Run ended without an upper edge |
| act_lo_o | output | TIME_W | Captured lower-edge timestamp |
| act_hi_o | output | TIME_W | Captured upper-edge timestamp |
| dev_lo_o | output | TIME_W+1 | Signed lower-edge deviation |
| dev_hi_o | output | TIME_W+1 | Signed upper-edge deviation |
| dle_o | output | TIME_W+2 | Signed differential linearity error in clocks |

## Verification
The assertions check on every cycle that done_o is a single-cycle pulse and never appears while busy, and that a start always sets busy. They also check that a timeout always comes with a fail, and that the reported error is the difference of the two deviations and agrees with the limit test. Once the run is idle, they check that the captured times and deviations do not change. The exact edge timestamps can only be shown by the bench scenarios. These scenarios include ramps that begin above the target, dips inside the code, skipped codes ending in a timeout, restarts in the middle of a run, and errors exactly at the limit.

// File: rtl/adc_dle_pkg.sv
package adc_dle_pkg;
  typedef enum logic [1:0] {
    SEEK_IDLE,
    SEEK_BELOW,
    SEEK_LOWER,
    SEEK_UPPER
  } seek_e;
endpackage

// File: rtl/adc_dle_timer.sv
module adc_dle_timer #(
  parameter int TIME_W      = 16,
  parameter int TIMEOUT_CYC = 4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  output logic [TIME_W-1:0] cnt_o,
  output logic              expired_o
);
  localparam logic [TIME_W-1:0] CntLimit = TIME_W'(TIMEOUT_CYC);

  logic [TIME_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (run_i && !expired_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign expired_o = (cnt_q == CntLimit);
endmodule

// File: rtl/adc_dle_edges.sv
module adc_dle_edges
  import adc_dle_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int TIME_W = 16,
  localparam int DevW  = TIME_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [CODE_W-1:0]      code_i,
  input  logic [CODE_W-1:0]      target_i,
  input  logic [TIME_W-1:0]      ideal_lo_i,
  input  logic [TIME_W-1:0]      ideal_hi_i,
  input  logic [TIME_W-1:0]      cnt_i,
  input  logic                   expired_i,
  output logic                   busy_o,
  output logic [TIME_W-1:0]      act_lo_o,
  output logic [TIME_W-1:0]      act_hi_o,
  output logic signed [DevW-1:0] dev_lo_o,
  output logic signed [DevW-1:0] dev_hi_o,
  output logic                   hi_evt_o,
  output logic                   to_evt_o
);
  seek_e             state_q;
  logic [TIME_W-1:0] ideal_lo_q, ideal_hi_q;
  logic              lo_hit, hi_hit;
  logic signed [DevW-1:0] now_s, ref_lo_s, ref_hi_s;

  assign now_s    = {1'b0, cnt_i};
  assign ref_lo_s = {1'b0, ideal_lo_q};
  assign ref_hi_s = {1'b0, ideal_hi_q};
  assign lo_hit   = (state_q == SEEK_LOWER) && (code_i == target_i);
  assign hi_hit   = (state_q == SEEK_UPPER) && (code_i >  target_i);
  assign busy_o   = (state_q != SEEK_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEEK_IDLE;
      ideal_lo_q <= '0;
      ideal_hi_q <= '0;
      act_lo_o   <= '0;
      act_hi_o   <= '0;
      dev_lo_o   <= '0;
      dev_hi_o   <= '0;
      hi_evt_o   <= 1'b0;
      to_evt_o   <= 1'b0;
    end else if (start_i) begin
      state_q    <= SEEK_BELOW;
      ideal_lo_q <= ideal_lo_i;
      ideal_hi_q <= ideal_hi_i;
      act_lo_o   <= '0;
      act_hi_o   <= '0;
      dev_lo_o   <= '0;
      dev_hi_o   <= '0;
      hi_evt_o   <= 1'b0;
      to_evt_o   <= 1'b0;
    end else begin
      hi_evt_o <= hi_hit;
      to_evt_o <= busy_o && expired_i && !hi_hit;
      if (hi_hit) begin
        act_hi_o <= cnt_i;
        dev_hi_o <= now_s - ref_hi_s;
        state_q  <= SEEK_IDLE;
      end else if (busy_o && expired_i) begin
        state_q  <= SEEK_IDLE;
      end else begin
        unique case (state_q)
          SEEK_BELOW: if (code_i < target_i) state_q <= SEEK_LOWER;
          SEEK_LOWER: if (lo_hit) begin
            act_lo_o <= cnt_i;
            dev_lo_o <= now_s - ref_lo_s;
            state_q  <= SEEK_UPPER;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_dle_judge.sv
module adc_dle_judge #(
  parameter int TIME_W = 16,
  localparam int DevW  = TIME_W + 1,
  localparam int DleW  = TIME_W + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   hi_evt_i,
  input  logic                   to_evt_i,
  input  logic signed [DevW-1:0] dev_lo_i,
  input  logic signed [DevW-1:0] dev_hi_i,
  input  logic [TIME_W-1:0]      limit_i,
  output logic                   done_o,
  output logic                   fail_o,
  output logic                   timeout_o,
  output logic signed [DleW-1:0] dle_o
);
  logic signed [DleW-1:0] diff;
  logic [DleW-1:0]        mag;
  logic                   over;

  assign diff = {dev_hi_i[DevW-1], dev_hi_i} - {dev_lo_i[DevW-1], dev_lo_i};
  assign mag  = diff[DleW-1] ? DleW'(-diff) : DleW'(diff);
  assign over = mag > {2'b00, limit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
      timeout_o <= 1'b0;
      dle_o     <= '0;
    end else if (start_i) begin
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
      timeout_o <= 1'b0;
      dle_o     <= '0;
    end else begin
      done_o <= hi_evt_i || to_evt_i;
      if (hi_evt_i) begin
        dle_o  <= diff;
        fail_o <= over;
      end else if (to_evt_i) begin
        dle_o     <= '0;
        fail_o    <= 1'b1;
        timeout_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_dle_bist.sv
module adc_dle_bist #(
  parameter int CODE_W      = 8,
  parameter int TIME_W      = 16,
  parameter int TIMEOUT_CYC = 4000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [CODE_W-1:0]        code_i,
  input  logic [CODE_W-1:0]        target_i,
  input  logic [TIME_W-1:0]        ideal_lo_i,
  input  logic [TIME_W-1:0]        ideal_hi_i,
  input  logic [TIME_W-1:0]        limit_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     fail_o,
  output logic                     timeout_o,
  output logic [TIME_W-1:0]        act_lo_o,
  output logic [TIME_W-1:0]        act_hi_o,
  output logic signed [TIME_W:0]   dev_lo_o,
  output logic signed [TIME_W:0]   dev_hi_o,
  output logic signed [TIME_W+1:0] dle_o
);
  logic [TIME_W-1:0] cnt;
  logic              expired, hi_evt, to_evt;

  adc_dle_timer #(.TIME_W(TIME_W), .TIMEOUT_CYC(TIMEOUT_CYC)) i_timer (
    .clk_i, .rst_ni,
    .clr_i     (start_i),
    .run_i     (busy_o),
    .cnt_o     (cnt),
    .expired_o (expired)
  );

  adc_dle_edges #(.CODE_W(CODE_W), .TIME_W(TIME_W)) i_edges (
    .clk_i, .rst_ni, .start_i, .code_i, .target_i, .ideal_lo_i, .ideal_hi_i,
    .cnt_i     (cnt),
    .expired_i (expired),
    .busy_o, .act_lo_o, .act_hi_o, .dev_lo_o, .dev_hi_o,
    .hi_evt_o  (hi_evt),
    .to_evt_o  (to_evt)
  );

  adc_dle_judge #(.TIME_W(TIME_W)) i_judge (
    .clk_i, .rst_ni, .start_i,
    .hi_evt_i (hi_evt),
    .to_evt_i (to_evt),
    .dev_lo_i (dev_lo_o),
    .dev_hi_i (dev_hi_o),
    .limit_i, .done_o, .fail_o, .timeout_o, .dle_o
  );
endmodule

// File: rtl/adc_dle_bist_chk.sv
module adc_dle_bist_chk #(
  parameter int TIME_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic [TIME_W-1:0]        limit_i,
  input logic                     busy_o,
  input logic                     done_o,
  input logic                     fail_o,
  input logic                     timeout_o,
  input logic [TIME_W-1:0]        act_lo_o,
  input logic [TIME_W-1:0]        act_hi_o,
  input logic signed [TIME_W:0]   dev_lo_o,
  input logic signed [TIME_W:0]   dev_hi_o,
  input logic signed [TIME_W+1:0] dle_o
);
  logic signed [TIME_W+1:0] dev_diff;
  logic [TIME_W+1:0]        dle_mag;
  logic                     in_band;

  assign dev_diff = {dev_hi_o[TIME_W], dev_hi_o} - {dev_lo_o[TIME_W], dev_lo_o};
  assign dle_mag  = dle_o[TIME_W+1] ? -dle_o : dle_o;
  assign in_band  = dle_mag <= {2'b00, limit_i};

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R2
  AST_DLE_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !timeout_o) |-> (dle_o == dev_diff)); // R6
  AST_PASS_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !timeout_o && in_band) |-> !fail_o); // R7
  AST_FAIL_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !in_band) |-> fail_o); // R7
  AST_TIMEOUT_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> fail_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !busy_o) |=> ($stable(act_lo_o) && $stable(act_hi_o) &&
                               $stable(dev_lo_o) && $stable(dev_hi_o))); // R10
endmodule

bind adc_dle_bist adc_dle_bist_chk #(.TIME_W(TIME_W)) i_chk (
  .clk_i, .rst_ni, .start_i, .limit_i, .busy_o, .done_o, .fail_o,
  .timeout_o, .act_lo_o, .act_hi_o, .dev_lo_o, .dev_hi_o, .dle_o
);

// File: tb/test_adc_dle_bist.sv
`timescale 1ns/1ps
module test_adc_dle_bist;
  localparam int CW = 6;
  localparam int TW = 12;
  localparam int TO = 300;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CW-1:0] code = '0, target = '0;
  logic [TW-1:0] ideal_lo = '0, ideal_hi = '0, limit = '0;
  logic busy, done, fail, tout;
  logic [TW-1:0] act_lo, act_hi;
  logic signed [TW:0] dev_lo, dev_hi;
  logic signed [TW+1:0] dle;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  adc_dle_bist #(.CODE_W(CW), .TIME_W(TW), .TIMEOUT_CYC(TO)) i_adc_dle_bist (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .code_i(code), .target_i(target),
    .ideal_lo_i(ideal_lo), .ideal_hi_i(ideal_hi), .limit_i(limit),
    .busy_o(busy), .done_o(done), .fail_o(fail), .timeout_o(tout),
    .act_lo_o(act_lo), .act_hi_o(act_hi), .dev_lo_o(dev_lo), .dev_hi_o(dev_hi), .dle_o(dle)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // mode 0 plain ramp, 1 starts above target, 2 dip inside code, 3 skipped code
  function automatic int code_at(int mode, int t, int tgt, int tlo, int thi);
    if (mode == 1 && t < 3) return tgt + 2;
    if (mode == 2 && t == tlo + 1) return tgt - 1;
    if (t < tlo) return tgt - 1;
    if (mode == 3) return tgt + 1;
    if (t < thi) return tgt;
    return tgt + 1;
  endfunction

  task automatic measure(int mode, int tgt, int ilo, int ihi, int tlo, int thi, int lim);
    int t_done = -1;
    int d_lo, d_hi, e_dle, e_fail;
    target = CW'(tgt); ideal_lo = TW'(ilo); ideal_hi = TW'(ihi); limit = TW'(lim);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2", "busy after start", int'(busy), 1);
    chk("R2", "cleared flags", int'({done, fail, tout}), 0);
    chk("R2", "cleared times", int'(act_lo) + int'(act_hi), 0);
    for (int t = 0; t < 400 && t_done < 0; t++) begin
      code = CW'(code_at(mode, t, tgt, tlo, thi));
      @(negedge clk);
      if (done) t_done = t;
    end
    if (mode == 3) begin
      chk("R8", "done time", t_done, TO + 1);
      chk("R8", "timeout", int'(tout), 1);
      chk("R8", "fail", int'(fail), 1);
      chk("R8", "dle", int'(dle), 0);
    end else begin
      d_lo = tlo - ilo; d_hi = thi - ihi; e_dle = d_hi - d_lo;
      e_fail = ((e_dle < 0 ? -e_dle : e_dle) > lim) ? 1 : 0;
      chk("R9", "done time", t_done, thi + 1);
      chk("R9", "busy low at done", int'(busy), 0);
      chk("R3", "act_lo", int'(act_lo), tlo);
      chk("R4", "act_hi", int'(act_hi), thi);
      chk("R5", "dev_lo", int'(dev_lo), d_lo);
      chk("R5", "dev_hi", int'(dev_hi), d_hi);
      chk("R6", "dle", int'(dle), e_dle);
      chk("R7", "fail", int'(fail), e_fail);
      chk("R8", "no timeout", int'(tout), 0);
    end
    @(negedge clk);
    chk("R9", "done one cycle", int'(done), 0);
  endtask

  task automatic hold_check();
    int s_lo = int'(act_lo), s_hi = int'(act_hi), s_dle = int'(dle), s_f = int'(fail);
    for (int i = 0; i < 8; i++) begin
      code = CW'($urandom);
      @(negedge clk);
    end
    chk("R10", "act_lo held", int'(act_lo), s_lo);
    chk("R10", "act_hi held", int'(act_hi), s_hi);
    chk("R10", "dle held", int'(dle), s_dle);
    chk("R10", "fail held", int'(fail), s_f);
    chk("R10", "no new done", int'(done), 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset flags", int'({busy, done, fail, tout}), 0);
    chk("R1", "reset values", int'(act_lo) + int'(act_hi) + int'(dev_lo) + int'(dev_hi) + int'(dle), 0);

    // directed: error equal to limit passes, one over fails
    measure(0, 20, 20, 40, 22, 40, 2);
    measure(0, 20, 20, 40, 22, 40, 1);
    // early lower edge, negative deviation
    measure(1, 33, 30, 50, 27, 52, 4);
    hold_check();
    measure(2, 5, 40, 60, 41, 58, 0);
    // skipped code
    measure(3, 12, 20, 30, 20, 30, 5);
    hold_check();
    // restart mid-run (R11)
    target = 6'd9; ideal_lo = 12'd10; ideal_hi = 12'd20;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    code = 6'd8; @(negedge clk);
    code = 6'd9; repeat (4) @(negedge clk);
    chk("R11", "busy in middle of run", int'(busy), 1);
    measure(0, 9, 15, 25, 16, 27, 3);
    chk("R11", "fresh act_lo after restart", int'(act_lo), 16);

    for (int n = 0; n < 30; n++) begin
      int ilo = 10 + int'($urandom % 100);
      int ihi = ilo + 8 + int'($urandom % 40);
      int tlo = ilo - 4 + int'($urandom % 9);
      int w   = (ihi - ilo) - 5 + int'($urandom % 11);
      int tgt = 2 + int'($urandom % 58);
      measure(int'($urandom % 3), tgt, ilo, ihi, tlo, tlo + w, int'($urandom % 8));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule